// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive-side DMA engine of a small switch. Software builds a ring of 32-byte descriptors in memory. Each descriptor that software hands over points at one empty buffer. The engine walks the ring, checks who owns each descriptor, and places each incoming frame into the buffer of the next descriptor that the hardware owns. It then records the received length, the source switch port, a protocol code and error flags, and hands the descriptor back to software by setting its owner bit. A one-cycle interrupt pulse marks every descriptor returned.

The engine is a single state machine with these states: `S_IDLE`, `S_RD_CTRL`, `S_RD_PTR`, `S_BACKOFF`, `S_RECV`, `S_WR_DATA`, `S_WB_INFO` and `S_WB_CTRL`. Its transitions are:

- **Poll** (`S_IDLE`→`S_RD_CTRL`): taken when the control input reads "run".
- **Owned by software** (`S_RD_CTRL`→`S_BACKOFF`): taken when the control word shows the owner bit set. From `S_BACKOFF` the **re-poll** transition returns to `S_IDLE` after `POLL_GAP` cycles.
- **Granted** (`S_RD_CTRL`→`S_RD_PTR`): taken when the descriptor belongs to the hardware.
- **Pointer loaded** (`S_RD_PTR`→`S_RECV`).
- **Word in** (`S_RECV`→`S_WR_DATA`): taken when a word arrives and the buffer still has room.
- **Word written** (`S_WR_DATA`→`S_RECV`), or **frame end** (`S_WR_DATA`→`S_WB_INFO`) when that word was the last one.
- **Overflow end** (`S_RECV`→`S_WB_INFO`): taken when the last word of the frame falls beyond the buffer.
- **Info written** (`S_WB_INFO`→`S_WB_CTRL`).
- **Returned** (`S_WB_CTRL`→`S_IDLE`): the descriptor pointer advances and the interrupt fires.

While the engine holds no descriptor it keeps `in_ready` low, so the frame source is held off.

The memory port is a simple request/acknowledge master. A request holds its address and data until `mem_ack`, and read data is valid with `mem_ack`. Frames arrive as 32-bit words. The sideband fields (port, protocol, CRC error) are taken from the first word of each frame.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `mem_req`, `rx_irq` and `in_ready` are all low.
- R2: The engine fetches descriptors only while `poll_ctrl` equals 2'b10. Bit 1 is the poll enable and bit 0 is the suspend bit. With enable low, or with suspend high, no new memory request starts from idle.
- R3: A fetch first reads the control word at descriptor address + 4, then reads the buffer pointer at + 0. A request holds its address steady until acknowledged.
- R4: If the control word has bit 31 (owner) set, the engine writes nothing, keeps `in_ready` low and reads the control word again `POLL_GAP` cycles later.
- R5: Frame word i is written to the buffer pointer + 4*i, in arrival order.
- R6: The returned control word at +4 has the following fields:
  - bits [15:0]: the stored length in bytes;
  - bits [21:18]: the protocol code;
  - bits 16 and 17: zero;
  - bits 28 (last segment) and 29 (first segment): set;
  - bit 30 (end of ring): kept from the fetched word;
  - bit 31 (owner): set.
- R7: The info word at +8 has the source port in bits [10:8], the CRC-error flag in bit 11 and a truncation flag in bit 12. All its other bits are zero.
- R8: For each frame, the info word is written before the control word, so ownership passes last.
- R9: The buffer size (bits [15:0] of the fetched control word) is a multiple of 4. Words arriving beyond the buffer size are accepted but not written. The stored length is then the buffer size, and the truncation flag is set.
- R10: After a descriptor is returned, the next descriptor is at its address + 32. If its end-of-ring bit was set, the next descriptor is at `ring_base` instead. While poll enable is low, the pointer follows `ring_base`.
- R11: `rx_irq` is a one-cycle pulse, one for each returned descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ring_base | input | AW | Byte address of the first descriptor |
| poll_ctrl | input | 2 | Bit 1 poll enable, bit 0 suspend |
| in_valid | input | 1 | Frame word valid |
| in_ready | output | 1 | Engine accepts a frame word |
| in_data | input | 32 | Frame word |
| in_last | input | 1 | Last word of the frame |
| in_port | input | 3 | Source switch port (first word) |
| in_proto | input | 4 | Protocol code (first word) |
| in_crc_err | input | 1 | CRC error seen (first word) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with ack |
| mem_ack | input | 1 | Request complete |
| rx_irq | output | 1 | Descriptor-returned pulse |

## Verification
The two functions that can coincide are the return of a descriptor and a suspend request. The bench watches for the owner-setting write of one frame and raises the suspend bit in exactly the cycle its acknowledge is presented. The returned descriptor must still complete with its owner bit set and its interrupt pulse, while no new descriptor fetch may start until suspend is released.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_RD_CTRL, S_RD_PTR, S_BACKOFF,
        S_RECV, S_WR_DATA, S_WB_INFO, S_WB_CTRL
    } rxr_state_t;

    localparam int B_OWN    = 31;
    localparam int B_EOR    = 30;
    localparam int B_FIRST  = 29;
    localparam int B_LAST   = 28;
    localparam int PROTO_LO = 18;
    localparam int PORT_LO  = 8;
    localparam int B_CRC    = 11;
    localparam int B_TRUNC  = 12;
    localparam int DESC_BYTES = 32;
    localparam logic [1:0] POLL_RUN = 2'b10;
endpackage

// File: rtl/rxr_wb.sv
module rxr_wb
    import rxr_pkg::*;
(
    input  logic [15:0] len,
    input  logic [3:0]  proto,
    input  logic        eor,
    input  logic [2:0]  port,
    input  logic        crc,
    input  logic        trunc,
    output logic [31:0] ctrl_word,
    output logic [31:0] info_word
);
    always_comb begin
        ctrl_word = '0;
        ctrl_word[15:0] = len;
        ctrl_word[PROTO_LO +: 4] = proto;
        ctrl_word[B_LAST]  = 1'b1;
        ctrl_word[B_FIRST] = 1'b1;
        ctrl_word[B_EOR]   = eor;
        ctrl_word[B_OWN]   = 1'b1;
        info_word = '0;
        info_word[PORT_LO +: 3] = port;
        info_word[B_CRC]   = crc;
        info_word[B_TRUNC] = trunc;
    end
endmodule

// File: rtl/rxr_ptr.sv
module rxr_ptr
    import rxr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [AW-1:0] base,
    input  logic          advance,
    input  logic          eor,
    output logic [AW-1:0] cur
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur <= '0;
        else if (!run_en)
            cur <= base;
        else if (advance)
            cur <= eor ? base : cur + AW'(DESC_BYTES);
    end

    // R10
    wrap_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && advance && eor) |=> (cur == $past(base)));
    // R10
    step_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && advance && !eor) |=> (cur == $past(cur) + AW'(DESC_BYTES)));
endmodule

// File: rtl/rxr_fsm.sv
module rxr_fsm
    import rxr_pkg::*;
#(
    parameter int AW       = 32,
    parameter int POLL_GAP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    poll_ctrl,
    input  logic [AW-1:0] desc_addr,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [31:0]   in_data,
    input  logic          in_last,
    input  logic [2:0]    in_port,
    input  logic [3:0]    in_proto,
    input  logic          in_crc_err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    output logic          advance,
    output logic          eor_q,
    output logic          rx_irq
);
    localparam int GAP_W = $clog2(POLL_GAP + 1);

    rxr_state_t st, st_nx;
    logic [AW-1:0]    buf_ptr, wr_addr;
    logic [15:0]      buf_size, rep_len;
    logic [16:0]      byte_cnt;
    logic [31:0]      wdat, ctrl_word, info_word;
    logic             last_q, trunc_q, crc_q, room, run;
    logic [2:0]       port_q;
    logic [3:0]       proto_q;
    logic [GAP_W-1:0] gap;

    assign run     = (poll_ctrl == POLL_RUN);
    assign room    = byte_cnt < {1'b0, buf_size};
    assign rep_len = room ? byte_cnt[15:0] : buf_size;

    rxr_wb u_wb (
        .len(rep_len), .proto(proto_q), .eor(eor_q), .port(port_q),
        .crc(crc_q), .trunc(trunc_q), .ctrl_word(ctrl_word), .info_word(info_word)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:    if (run) st_nx = S_RD_CTRL;
            S_RD_CTRL: if (mem_ack) st_nx = mem_rdata[B_OWN] ? S_BACKOFF : S_RD_PTR;
            S_RD_PTR:  if (mem_ack) st_nx = S_RECV;
            S_BACKOFF: if (gap == GAP_W'(POLL_GAP - 1)) st_nx = S_IDLE;
            S_RECV:    if (in_valid) begin
                           if (room)         st_nx = S_WR_DATA;
                           else if (in_last) st_nx = S_WB_INFO;
                       end
            S_WR_DATA: if (mem_ack) st_nx = last_q ? S_WB_INFO : S_RECV;
            S_WB_INFO: if (mem_ack) st_nx = S_WB_CTRL;
            S_WB_CTRL: if (mem_ack) st_nx = S_IDLE;
            default:   st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_ptr <= '0; wr_addr <= '0; buf_size <= '0; byte_cnt <= '0;
            wdat <= '0; last_q <= 1'b0; trunc_q <= 1'b0; crc_q <= 1'b0;
            port_q <= '0; proto_q <= '0; gap <= '0; eor_q <= 1'b0; rx_irq <= 1'b0;
        end else begin
            rx_irq <= (st == S_WB_CTRL) && mem_ack;
            gap    <= (st == S_BACKOFF) ? gap + 1'b1 : '0;
            if (st == S_RD_CTRL && mem_ack && !mem_rdata[B_OWN]) begin
                buf_size <= mem_rdata[15:0];
                eor_q    <= mem_rdata[B_EOR];
            end
            if (st == S_RD_PTR && mem_ack) begin
                buf_ptr  <= mem_rdata[AW-1:0];
                byte_cnt <= '0;
                trunc_q  <= 1'b0;
            end
            if (st == S_RECV && in_valid) begin
                if (byte_cnt == '0) begin
                    port_q  <= in_port;
                    proto_q <= in_proto;
                    crc_q   <= in_crc_err;
                end
                byte_cnt <= byte_cnt + 17'd4;
                last_q   <= in_last;
                if (room) begin
                    wdat    <= in_data;
                    wr_addr <= buf_ptr + AW'(byte_cnt);
                end else begin
                    trunc_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = '0;
        in_ready  = (st == S_RECV);
        advance   = (st == S_WB_CTRL) && mem_ack;
        unique case (st)
            S_RD_CTRL: begin mem_req = 1'b1; mem_addr = desc_addr + AW'(4); end
            S_RD_PTR:  begin mem_req = 1'b1; end
            S_WR_DATA: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = wr_addr; mem_wdata = wdat; end
            S_WB_INFO: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = desc_addr + AW'(8); mem_wdata = info_word; end
            S_WB_CTRL: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = desc_addr + AW'(4); mem_wdata = ctrl_word; end
            default: ;
        endcase
    end

    // R11
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);
    // R2
    no_fetch_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && !run) |=> !mem_req);
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
    // R4
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RD_CTRL && mem_ack && mem_rdata[B_OWN]) |=> (!in_ready && !mem_we));
    // R9
    trunc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WR_DATA) |-> ((wr_addr - buf_ptr) < AW'(buf_size)));
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int AW       = 32,
    parameter int POLL_GAP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_base,
    input  logic [1:0]    poll_ctrl,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [31:0]   in_data,
    input  logic          in_last,
    input  logic [2:0]    in_port,
    input  logic [3:0]    in_proto,
    input  logic          in_crc_err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    output logic          rx_irq
);
    logic [AW-1:0] desc_addr;
    logic          advance, eor_q;

    rxr_ptr #(.AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .run_en(poll_ctrl[1]), .base(ring_base),
        .advance(advance), .eor(eor_q), .cur(desc_addr)
    );

    rxr_fsm #(.AW(AW), .POLL_GAP(POLL_GAP)) u_fsm (
        .clk(clk), .rst_n(rst_n), .poll_ctrl(poll_ctrl), .desc_addr(desc_addr),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_port(in_port), .in_proto(in_proto),
        .in_crc_err(in_crc_err), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .advance(advance), .eor_q(eor_q), .rx_irq(rx_irq)
    );
endmodule

// File: tb/rx_ring_writer_tb.sv
`timescale 1ns/1ps
module rx_ring_writer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ring_base = 32'h100;
    logic [1:0]  poll_ctrl = 2'b00;
    logic        in_valid = 1'b0, in_last = 1'b0, in_crc_err = 1'b0;
    logic [31:0] in_data = '0;
    logic [2:0]  in_port = '0;
    logic [3:0]  in_proto = '0;
    logic        in_ready, mem_req, mem_we, mem_ack, rx_irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    always #2 clk = ~clk;

    rx_ring_writer u_dut (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .poll_ctrl(poll_ctrl),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_port(in_port), .in_proto(in_proto),
        .in_crc_err(in_crc_err), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .rx_irq(rx_irq)
    );

    // memory model with a software write port
    logic [31:0] mem [256];
    logic        sw_we = 1'b0;
    logic [31:0] sw_addr = '0, sw_data = '0;
    logic [31:0] prev_wa, last_wa, first_ra;
    logic        first_seen;
    int          rd104 = 0, rd100 = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 256; k++) mem[k] <= 32'hA5A50000 | k;
            mem_ack <= 1'b0; mem_rdata <= '0; prev_wa <= '0; last_wa <= '0;
            first_seen <= 1'b0; first_ra <= '0;
        end else begin
            if (sw_we) mem[sw_addr[9:2]] <= sw_data;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[9:2]] <= mem_wdata;
                    prev_wa <= last_wa; last_wa <= mem_addr;
                end else begin
                    mem_rdata <= mem[mem_addr[9:2]];
                    if (!first_seen) begin first_seen <= 1'b1; first_ra <= mem_addr; end
                    if (mem_addr == 32'h104) rd104 <= rd104 + 1;
                    if (mem_addr == 32'h100) rd100 <= rd100 + 1;
                end
            end else mem_ack <= 1'b0;
        end
    end

    int nrun = 0, nfail = 0, irq_cnt = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nrun++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sw_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); sw_we = 1'b1; sw_addr = a; sw_data = d;
        @(negedge clk); sw_we = 1'b0;
    endtask

    function automatic logic [31:0] give_word(input logic eor);
        return (32'(eor) << 30) | (32'h1 << 29) | (32'h1 << 28) | 32'd16;
    endfunction

    typedef struct {
        logic [31:0] daddr, bufa, seed;
        int          nw;
        logic [2:0]  port;
        logic [3:0]  proto;
        logic        crc, eor;
    } item_t;
    item_t exp_q[$];

    task automatic send_frame(input logic [31:0] da, input logic [31:0] ba, input int nw,
                              input logic [2:0] p, input logic [3:0] pr, input logic c,
                              input logic e, input logic [31:0] seed);
        item_t it;
        it.daddr = da; it.bufa = ba; it.seed = seed; it.nw = nw;
        it.port = p; it.proto = pr; it.crc = c; it.eor = e;
        exp_q.push_back(it);
        for (int i = 0; i < nw; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = seed + 32'(i); in_last = (i == nw - 1);
            in_port = p; in_proto = pr; in_crc_err = c;
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rx_irq) begin
                irq_cnt++;
                if (exp_q.size() == 0) chk("R11 unexpected irq", 32'd1, 32'd0);
                else begin
                    item_t it;
                    int nb, nst;
                    logic [31:0] w1, w2;
                    it = exp_q.pop_front();
                    nb  = it.nw * 4;
                    nst = (nb > 16) ? 16 : nb;
                    w1 = (32'h1 << 31) | (32'(it.eor) << 30) | (32'h1 << 29) | (32'h1 << 28)
                         | (32'(it.proto) << 18) | 32'(nst);
                    w2 = (32'(nb > 16) << 12) | (32'(it.crc) << 11) | (32'(it.port) << 8);
                    chk("R6 ctrl word", mem[(it.daddr + 4) >> 2], w1);
                    chk("R7 info word", mem[(it.daddr + 8) >> 2], w2);
                    for (int i = 0; i < nst / 4; i++)
                        chk("R5 buffer word", mem[(it.bufa >> 2) + i], it.seed + 32'(i));
                    chk("R8 info before ctrl", prev_wa, it.daddr + 8);
                    chk("R8 ctrl last", last_wa, it.daddr + 4);
                end
                @(negedge clk);
                chk("R11 irq one cycle", {31'd0, rx_irq}, 32'd0);
            end
        end
    end

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nrun++; nfail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        summary();
        $finish;
    end

    initial begin
        int bad;
        repeat (3) @(negedge clk);
        chk("R1 mem_req reset", {31'd0, mem_req}, 32'd0);
        chk("R1 irq reset", {31'd0, rx_irq}, 32'd0);
        chk("R1 in_ready reset", {31'd0, in_ready}, 32'd0);
        rst_n = 1'b1;
        // descriptors: 0x100, 0x120, 0x140 (end of ring), buffers 0x200/0x240/0x280
        sw_write(32'h104, give_word(1'b0) | (32'h1 << 31));  // owned by software
        sw_write(32'h100, 32'h200);
        sw_write(32'h124, give_word(1'b0));
        sw_write(32'h120, 32'h240);
        sw_write(32'h144, give_word(1'b1));
        sw_write(32'h140, 32'h280);

        bad = 0;
        repeat (20) begin @(negedge clk); if (mem_req) bad = 1; end
        chk("R2 no fetch when disabled", 32'(bad), 32'd0);
        poll_ctrl = 2'b11;
        bad = 0;
        repeat (20) begin @(negedge clk); if (mem_req) bad = 1; end
        chk("R2 no fetch when suspended", 32'(bad), 32'd0);

        poll_ctrl = 2'b10;
        bad = 0;
        repeat (40) begin @(negedge clk); if (in_ready || (mem_req && mem_we)) bad = 1; end
        chk("R3 first read is ctrl word", first_ra, 32'h104);
        chk("R4 held off while owned", 32'(bad), 32'd0);
        chk("R4 repolled", 32'(rd104 >= 2), 32'd1);
        chk("R4 pointer not read", 32'(rd100), 32'd0);
        chk("R4 buffer untouched", mem[32'h200 >> 2], 32'hA5A50080);

        sw_write(32'h104, give_word(1'b0));
        send_frame(32'h100, 32'h200, 3, 3'd1, 4'd5,  1'b0, 1'b0, 32'h1000);
        send_frame(32'h120, 32'h240, 4, 3'd4, 4'd13, 1'b1, 1'b0, 32'h2000);
        send_frame(32'h140, 32'h280, 6, 3'd2, 4'd1,  1'b0, 1'b1, 32'h3000);
        repeat (10) @(negedge clk);
        chk("R9 beyond buffer untouched", mem[32'h290 >> 2], 32'hA5A500A4);

        sw_write(32'h104, give_word(1'b0));
        send_frame(32'h100, 32'h200, 2, 3'd0, 4'd2, 1'b1, 1'b0, 32'h4000);
        // suspend exactly in the ack cycle of the owner-returning write
        while (!(mem_req && mem_we && mem_addr == 32'h104)) @(negedge clk);
        while (!mem_ack) @(negedge clk);
        poll_ctrl = 2'b11;
        repeat (4) @(negedge clk);
        bad = 0;
        repeat (30) begin @(negedge clk); if (mem_req) bad = 1; end
        chk("R2 suspend at return blocks fetch", 32'(bad), 32'd0);
        chk("R10 no descriptor past end", mem[32'h164 >> 2], 32'hA5A50059);
        chk("R11 irq count", 32'(irq_cnt), 32'd4);
        chk("R11 scoreboard drained", 32'(exp_q.size()), 32'd0);
        poll_ctrl = 2'b10;
        repeat (30) @(negedge clk);
        chk("R4 returned descriptor kept", mem[32'h124 >> 2] >> 31, 32'd1);
        summary();
        $finish;
    end
endmodule